// File: doc/BRIEF.md
# Decimal Rotor Cipher Core

This block enciphers one decimal digit per key press with a single stepping rotor. Each digit is a 4-bit BCD code. A key press first moves a position counter one step around a cycle of ten (0 to 9, then back to 0). The digit then goes through three stages. The first is the rotor wiring, shifted by the new position. The second is a fixed reflector that pairs digits. The third is the exact inverse of the same shifted rotor. The result comes out on a registered output one clock later.

The return path is the true inverse of the forward wiring, and the reflector is an involution with no fixed points. As a result, the whole substitution at any position is its own inverse. Feeding the ciphertext back at the same rotor position returns the plaintext. The position counter is visible at the ports, so a controller can track where the rotor stands. A controller reaches position N by resetting the block and pressing N keys.

Top module: `dec_rotor_cipher`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rotor_pos` is 0, and `out_vld`, `out_err` and `out_dig` are all 0 until the first key press.
- R2: A key press (`key_vld`=1) with a legal digit (codes 0..9) moves `rotor_pos` from c to c+1, with 9 wrapping to 0. The new value is visible one clock after the press.
- R3: `out_vld` is 1 in exactly the cycle after each key press, whether the code is legal or not, and is 0 otherwise.
- R4: Rotor wiring R is 0→3, 1→7, 2→0, 3→9, 4→1, 5→8, 6→2, 7→5, 8→4, 9→6. At position p the forward stage maps x to (R[(x+p) mod 10] − p) mod 10, and the return stage applies the inverse of R with the same shift. Here p is the position after the step taken by that key press.
- R5: The reflector pairs 0↔5, 1↔7, 2↔9, 3↔8 and 4↔6. A legal digit never enciphers to itself.
- R6: For every position 0..9 and every digit m, enciphering m and then enciphering the result at the same position gives back m.
- R7: A key press with an illegal code (10..15) gives `out_dig`=0 and `out_err`=1 with `out_vld`=1, and leaves `rotor_pos` unchanged.
- R8: In a cycle without a key press, `rotor_pos` and `out_dig` keep their values, and `out_err` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| key_vld | input | 1 | Key-press strobe, one digit per cycle it is high |
| key_dig | input | 4 | BCD digit to encipher |
| out_dig | output | 4 | Enciphered BCD digit |
| out_vld | output | 1 | High one cycle after each key press |
| out_err | output | 1 | The press that produced this output carried a non-BCD code |
| rotor_pos | output | 4 | Current rotor position, 0..9 |

## Verification
The only state inside the block is the rotor position. A wrong position shows up at the `rotor_pos` port one clock after the faulty press. It also corrupts the very next cipher digit, because the cipher uses the stepped value. A return stage that is not the true inverse of the forward wiring can look plausible at position 0. It only shows when ciphertext is fed back and fails to come home, so the bench runs that round trip at all ten positions for all ten digits. An illegal code that wrongly advances the counter shifts every later digit, and the per-clock comparison with the reference model catches that on the next press.

// File: rtl/drc_pkg.sv
package drc_pkg;
  localparam int DIG_W = 4;
  localparam int N_SYM = 10;
  localparam int SUM_W = DIG_W + 1;

  typedef logic [DIG_W-1:0] digit_t;

  function automatic digit_t mod_add(digit_t a, digit_t b);
    logic [SUM_W-1:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= SUM_W'(N_SYM)) s = s - SUM_W'(N_SYM);
    return s[DIG_W-1:0];
  endfunction

  function automatic digit_t mod_sub(digit_t a, digit_t b);
    digit_t r;
    if (a >= b) r = a - b;
    else        r = a + DIG_W'(N_SYM) - b;
    return r;
  endfunction

  function automatic digit_t wiring_fwd(digit_t x);
    digit_t r;
    case (x)
      4'd0: r = 4'd3;
      4'd1: r = 4'd7;
      4'd2: r = 4'd0;
      4'd3: r = 4'd9;
      4'd4: r = 4'd1;
      4'd5: r = 4'd8;
      4'd6: r = 4'd2;
      4'd7: r = 4'd5;
      4'd8: r = 4'd4;
      4'd9: r = 4'd6;
      default: r = 4'd0;
    endcase
    return r;
  endfunction

  // Inverse wiring is searched out of the forward table, never written by hand
  function automatic digit_t wiring_inv(digit_t x);
    digit_t r;
    r = '0;
    for (int i = 0; i < N_SYM; i++)
      if (wiring_fwd(DIG_W'(i)) == x) r = DIG_W'(i);
    return r;
  endfunction

  function automatic digit_t pair_swap(digit_t x);
    digit_t r;
    case (x)
      4'd0: r = 4'd5;
      4'd5: r = 4'd0;
      4'd1: r = 4'd7;
      4'd7: r = 4'd1;
      4'd2: r = 4'd9;
      4'd9: r = 4'd2;
      4'd3: r = 4'd8;
      4'd8: r = 4'd3;
      4'd4: r = 4'd6;
      4'd6: r = 4'd4;
      default: r = 4'd0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/drc_step_ctr.sv
module drc_step_ctr
  import drc_pkg::*;
#(
  parameter int MODULUS = N_SYM
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_en,
  output digit_t pos_q,
  output digit_t pos_nx
);
  localparam digit_t LAST = DIG_W'(MODULUS - 1);

  digit_t pos_d;

  always_comb begin
    pos_nx = (pos_q == LAST) ? '0 : pos_q + DIG_W'(1);
    pos_d  = step_en ? pos_nx : pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end
endmodule

// File: rtl/drc_rotor.sv
module drc_rotor
  import drc_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  digit_t sym_i,
  input  digit_t shift_i,
  output digit_t sym_o
);
  digit_t entry, tapped;

  assign entry = mod_add(sym_i, shift_i);

  generate
    if (INVERSE) begin : g_inv
      assign tapped = wiring_inv(entry);
    end else begin : g_fwd
      assign tapped = wiring_fwd(entry);
    end
  endgenerate

  assign sym_o = mod_sub(tapped, shift_i);
endmodule

// File: rtl/drc_reflector.sv
module drc_reflector
  import drc_pkg::*;
(
  input  digit_t sym_i,
  output digit_t sym_o
);
  assign sym_o = pair_swap(sym_i);
endmodule

// File: rtl/dec_rotor_cipher.sv
module dec_rotor_cipher
  import drc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_vld,
  input  logic [3:0] key_dig,
  output logic [3:0] out_dig,
  output logic       out_vld,
  output logic       out_err,
  output logic [3:0] rotor_pos
);
  logic   legal, step_en;
  digit_t pos_q, pos_nx, fwd_sym, ref_sym, ret_sym;
  digit_t dig_q, dig_d;
  logic   vld_q, vld_d, err_q, err_d;

  assign legal   = (key_dig < DIG_W'(N_SYM));
  assign step_en = key_vld & legal;

  drc_step_ctr #(.MODULUS(N_SYM)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_en(step_en),
    .pos_q  (pos_q),
    .pos_nx (pos_nx)
  );

  drc_rotor #(.INVERSE(1'b0)) u_fwd (
    .sym_i  (key_dig),
    .shift_i(pos_nx),
    .sym_o  (fwd_sym)
  );

  drc_reflector u_refl (
    .sym_i(fwd_sym),
    .sym_o(ref_sym)
  );

  drc_rotor #(.INVERSE(1'b1)) u_ret (
    .sym_i  (ref_sym),
    .shift_i(pos_nx),
    .sym_o  (ret_sym)
  );

  always_comb begin
    vld_d = key_vld;
    err_d = key_vld & ~legal;
    dig_d = dig_q;
    if (key_vld) dig_d = legal ? ret_sym : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      dig_q <= dig_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign out_dig   = dig_q;
  assign out_vld   = vld_q;
  assign out_err   = err_q;
  assign rotor_pos = pos_q;
endmodule

// File: rtl/drc_chk.sv
module drc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       key_vld,
  input logic [3:0] key_dig,
  input logic [3:0] out_dig,
  input logic       out_vld,
  input logic       out_err,
  input logic [3:0] rotor_pos
);
  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_vld && key_dig < 4'd10) |=>
      rotor_pos == (($past(rotor_pos) == 4'd9) ? 4'd0 : $past(rotor_pos) + 4'd1));

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rotor_pos <= 4'd9);

  // R3
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld |=> out_vld);

  // R3
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_vld |=> !out_vld);

  // R5
  no_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_vld && key_dig < 4'd10) |=> out_dig != $past(key_dig));

  // R7
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_vld && key_dig > 4'd9) |=> (out_err && out_dig == 4'd0 && $stable(rotor_pos)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_vld |=> ($stable(rotor_pos) && $stable(out_dig) && !out_err));
endmodule

bind dec_rotor_cipher drc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .key_vld  (key_vld),
  .key_dig  (key_dig),
  .out_dig  (out_dig),
  .out_vld  (out_vld),
  .out_err  (out_err),
  .rotor_pos(rotor_pos)
);

// File: tb/sim_dec_rotor_cipher.sv
`timescale 1ns/1ps
module sim_dec_rotor_cipher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_vld = 1'b0;
  logic [3:0] key_dig = 4'd0;
  logic [3:0] out_dig;
  logic       out_vld, out_err;
  logic [3:0] rotor_pos;

  int total = 0;
  int bad = 0;

  int rot [10] = '{3, 7, 0, 9, 1, 8, 2, 5, 4, 6};
  int refl[10] = '{5, 7, 9, 8, 6, 0, 4, 1, 3, 2};
  int rinv[10];

  // reference model state
  int m_pos = 0, m_dig = 0, m_vld = 0, m_err = 0;
  int last_out = 0;

  always #4 clk = ~clk;

  dec_rotor_cipher u0 (
    .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key_dig(key_dig),
    .out_dig(out_dig), .out_vld(out_vld), .out_err(out_err), .rotor_pos(rotor_pos)
  );

  function automatic int encipher(int x, int p);
    int y, z;
    y = (rot[(x + p) % 10] - p + 10) % 10;
    z = refl[y];
    return (rinv[(z + p) % 10] - p + 10) % 10;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check({req, " out_vld"}, out_vld, m_vld);
    check({req, " out_err"}, out_err, m_err);
    check({req, " rotor_pos"}, rotor_pos, m_pos);
    check({req, " out_dig"}, out_dig, m_dig);
  endtask

  // drive at negedge, update the model, check at the next negedge
  task automatic press(input bit v, input int d, input string req);
    key_vld = v;
    key_dig = 4'(d);
    if (v && d < 10) begin
      m_pos = (m_pos + 1) % 10;
      m_dig = encipher(d, m_pos);
      m_err = 0;
    end else if (v) begin
      m_dig = 0;
      m_err = 1;
    end else begin
      m_err = 0;
    end
    m_vld = v ? 1 : 0;
    @(negedge clk);
    last_out = out_dig;
    compare_all(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    key_vld = 1'b0;
    @(negedge clk);
    m_pos = 0; m_dig = 0; m_vld = 0; m_err = 0;
    compare_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int enc[10];
    for (int i = 0; i < 10; i++) rinv[rot[i]] = i;
    @(negedge clk);
    @(negedge clk);
    do_reset();

    // R4: known value, digit 0 at position 1 gives 6
    press(1, 0, "R4");
    check("R4 first cipher", out_dig, 6);
    // R2: full wrap through 9 back to 0
    for (int i = 0; i < 10; i++) press(1, i, "R2/R4 sweep");
    check("R2 wrap", rotor_pos, 1);
    // R8: idle cycles hold state
    press(0, 0, "R8 idle");
    check("R8 out_dig hold", out_dig, encipher(9, 1));
    press(0, 3, "R8 idle");
    // R7: illegal codes
    for (int c = 10; c < 16; c++) begin
      press(1, c, "R7 illegal");
      check("R7 err", out_err, 1);
      check("R7 dig", out_dig, 0);
    end
    press(1, 4, "R3 after illegal");
    // back-to-back mixed pattern
    for (int i = 0; i < 30; i++) press((i % 3) != 0, (i * 7) % 16, "R3 mixed");

    // R5 and R6: round trip at every position for every digit
    do_reset();
    for (int m = 0; m < 10; m++) begin
      for (int p = 0; p < 10; p++) begin
        press(1, m, "R6 encode");
        enc[p] = out_dig;
        if (out_dig == 4'(m)) check("R5 no fixed point", out_dig, 99);
      end
      for (int p = 0; p < 10; p++) begin
        press(1, enc[p], "R6 decode");
        check("R6 round trip", out_dig, m);
      end
    end

    // R1: reset in the middle of a run
    press(1, 2, "R2 pre-reset");
    press(1, 5, "R2 pre-reset");
    do_reset();
    check("R1 pos zero", rotor_pos, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule